// File: doc/BRIEF.md
# Logic Analyser Trigger Qualifier

This block decides when a logic-analyser capture may begin. It watches eight sampled logic inputs. Each input passes through a two-flop synchroniser before anything compares it. A per-pin select mask chooses which inputs take part. A polarity input chooses whether the trigger looks for a high or a low level. An input only produces a qualifying event when it moves into the active level. An input that merely sits at that level produces no event, with one exception: when the block is armed, a selected input that is already at the active level counts as an event straight away.

Software loads a required event count and a delay in milliseconds, then pulses `arm_i`. The block counts qualifying events. When the final event arrives, it counts pulses on `ms_tick_i`, an external 1 ms strobe, so the delay does not depend on the clock frequency. It then raises `start_o` for a single cycle and returns to idle. `busy_o` covers the whole armed period. `disarm_i` abandons a trigger at any point.

The controller has four states:
- ST_IDLE: not armed.
- ST_WAIT: counting events.
- ST_DELAY: counting ticks.
- ST_FIRE: the start pulse.

The transitions are:
- arm (IDLE to WAIT).
- arm-hit (IDLE to DELAY or FIRE, when the level present at arm is already the final event).
- final-event (WAIT to DELAY, or WAIT to FIRE when the delay is zero).
- delay-done (DELAY to FIRE).
- release (FIRE to IDLE).
- abort (any state to IDLE on disarm).

Top module: `trig_qualifier`

## Requirements
- R1: A change on `pin_i` passes through two synchroniser flops. With count 0 and delay 0, `start_o` is high in the cycle after the third rising clock edge that follows the change, and low in the two cycles before it.
- R2: A pin whose mask bit is 0 never produces an event, whatever it does.
- R3: With `active_high_i`=1 an event is a selected pin going 0 to 1. With `active_high_i`=0 an event is a selected pin going 1 to 0. A move back to the inactive level is not an event. Transitions on several pins in one cycle count as one event.
- R4: `start_o` follows qualifying event number `need_count_i`+1. A count of 0 therefore fires on the first event.
- R5: If a selected pin is at the active level (as synchronised) in the arm cycle, that counts as an event at once. That pin produces no further event until it leaves the active level and returns.
- R6: If the delay is 0, `start_o` follows the final event directly. Otherwise `start_o` is high in the cycle after the `delay_ms_i`-th `ms_tick_i` pulse that arrives after the final event. Ticks that arrive before the final event are not counted.
- R7: `start_o` lasts exactly one cycle. `busy_o` is high from the cycle after arm up to and including the start cycle, and low afterwards. `busy_o` only rises after an accepted arm.
- R8: The mask, polarity, count and delay are captured at arm. Changing them while busy has no effect. An arm pulse while busy is ignored and does not restart the count.
- R9: `disarm_i` sends the block to idle on the next cycle from any state and discards the counting progress. `disarm_i` takes priority over `arm_i`.
- R10: During and after reset, `start_o` and `busy_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| pin_i | input | 8 | sampled logic inputs |
| sel_mask_i | input | 8 | per-pin select mask |
| active_high_i | input | 1 | 1: trigger on high level, 0: on low level |
| need_count_i | input | 8 | events to skip before the firing event (0..254) |
| delay_ms_i | input | 8 | delay after final event in ms ticks (0..254) |
| arm_i | input | 1 | arm request |
| disarm_i | input | 1 | abort to idle |
| ms_tick_i | input | 1 | one-cycle strobe every millisecond |
| start_o | output | 1 | one-cycle capture start |
| busy_o | output | 1 | armed and not yet fired |

## Verification
The corner cases the bench targets are these:
- An input already active at arm. A design that ignored it would hang. A design that counted it again on the next sample would fire one event early.
- Returns to the inactive level and activity on deselected pins. A design that counted these would fire early.
- Tick pulses that arrive while events are still being counted. A design that kept them would shorten the delay.
- Re-arming while busy, and changing the settings after arm. A design that restarted or re-read the settings would fire at the wrong event.
- A disarm in the middle of counting. A design that kept the old event count would fire early after the next arm.

Random trials over mask, polarity, count and delay check the exact cycle of the start pulse.

// File: rtl/tq_pkg.sv
package tq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_DELAY = 2'd2,
        ST_FIRE  = 2'd3
    } tq_state_t;
endpackage

// File: rtl/tq_sync.sv
module tq_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], d_i[b]};
        end
        assign q_o[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/tq_edge.sv
module tq_edge #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sync_i,
    input  logic [W-1:0] live_mask_i,
    input  logic         live_pol_i,
    input  logic [W-1:0] held_mask_i,
    input  logic         held_pol_i,
    output logic         edge_hit_o,
    output logic         level_hit_o
);
    logic [W-1:0] prev_q;
    logic [W-1:0] held_active;
    logic [W-1:0] live_active;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sync_i;
    end

    assign held_active = held_pol_i ? sync_i : ~sync_i;
    assign live_active = live_pol_i ? sync_i : ~sync_i;

    // event: selected pin changed and now sits at the active level
    assign edge_hit_o  = |(held_mask_i & held_active & (sync_i ^ prev_q));
    // arm-time level check on the live settings
    assign level_hit_o = |(live_mask_i & live_active);
endmodule

// File: rtl/tq_delay.sv
module tq_delay #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic          tick_i,
    input  logic [DW-1:0] limit_i,
    output logic          done_o
);
    logic [DW-1:0] ms_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               ms_q <= '0;
        else if (!run_i)          ms_q <= '0;
        else if (tick_i && !done_o) ms_q <= ms_q + DW'(1);
    end

    assign done_o = run_i && tick_i && (ms_q == limit_i - DW'(1));
endmodule

// File: rtl/trig_qualifier.sv
module trig_qualifier
    import tq_pkg::*;
#(
    parameter int NPINS = 8,
    parameter int CW    = 8,
    parameter int DW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_i,
    input  logic [NPINS-1:0] sel_mask_i,
    input  logic             active_high_i,
    input  logic [CW-1:0]    need_count_i,
    input  logic [DW-1:0]    delay_ms_i,
    input  logic             arm_i,
    input  logic             disarm_i,
    input  logic             ms_tick_i,
    output logic             start_o,
    output logic             busy_o
);
    tq_state_t state_q, state_d;

    logic [NPINS-1:0] sync_pins;
    logic [NPINS-1:0] cfg_mask_q;
    logic             cfg_pol_q;
    logic [CW-1:0]    cfg_count_q;
    logic [DW-1:0]    cfg_delay_q;
    logic [CW-1:0]    ev_cnt_q;

    logic edge_hit, level_hit, delay_done;
    logic arm_go, qual, last_ev;
    logic [CW-1:0] cur_count;
    logic [DW-1:0] cur_delay;

    tq_sync #(.W(NPINS), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_i),
        .q_o   (sync_pins)
    );

    tq_edge #(.W(NPINS)) u_edge (
        .clk         (clk),
        .rst_n       (rst_n),
        .sync_i      (sync_pins),
        .live_mask_i (sel_mask_i),
        .live_pol_i  (active_high_i),
        .held_mask_i (cfg_mask_q),
        .held_pol_i  (cfg_pol_q),
        .edge_hit_o  (edge_hit),
        .level_hit_o (level_hit)
    );

    tq_delay #(.DW(DW)) u_delay (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (state_q == ST_DELAY && !disarm_i),
        .tick_i  (ms_tick_i),
        .limit_i (cfg_delay_q),
        .done_o  (delay_done)
    );

    assign arm_go    = arm_i && !disarm_i;
    assign cur_count = (state_q == ST_IDLE) ? need_count_i : cfg_count_q;
    assign cur_delay = (state_q == ST_IDLE) ? delay_ms_i   : cfg_delay_q;
    assign qual      = ((state_q == ST_IDLE) && arm_go && level_hit) ||
                       ((state_q == ST_WAIT) && edge_hit);
    assign last_ev   = qual && (((state_q == ST_IDLE) ? CW'(0) : ev_cnt_q) == cur_count);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (arm_go) begin
                    if (last_ev) state_d = (cur_delay == '0) ? ST_FIRE : ST_DELAY;
                    else         state_d = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (last_ev) state_d = (cur_delay == '0) ? ST_FIRE : ST_DELAY;
            end
            ST_DELAY: begin
                if (delay_done) state_d = ST_FIRE;
            end
            ST_FIRE: state_d = ST_IDLE;
        endcase
        if (disarm_i) state_d = ST_IDLE;
    end

    // settings capture and event counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_mask_q  <= '0;
            cfg_pol_q   <= 1'b1;
            cfg_count_q <= '0;
            cfg_delay_q <= '0;
            ev_cnt_q    <= '0;
        end else if (disarm_i) begin
            ev_cnt_q <= '0;
        end else if (state_q == ST_IDLE) begin
            if (arm_go) begin
                cfg_mask_q  <= sel_mask_i;
                cfg_pol_q   <= active_high_i;
                cfg_count_q <= need_count_i;
                cfg_delay_q <= delay_ms_i;
                ev_cnt_q    <= qual ? CW'(1) : CW'(0);
            end else begin
                ev_cnt_q <= '0;
            end
        end else if (state_q == ST_WAIT && qual) begin
            ev_cnt_q <= ev_cnt_q + CW'(1);
        end
    end

    // outputs
    always_comb begin
        start_o = (state_q == ST_FIRE);
        busy_o  = (state_q != ST_IDLE);
    end
endmodule

// File: rtl/tq_checker.sv
module tq_checker (
    input logic clk,
    input logic rst_n,
    input logic arm_i,
    input logic disarm_i,
    input logic start_o,
    input logic busy_o
);
    assert_start_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);
    assert_start_in_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> busy_o);
    assert_idle_after_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !busy_o);
    assert_busy_needs_arm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> ($past(arm_i) && !$past(disarm_i)));
    assert_disarm_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        disarm_i |=> !busy_o);
    always_comb begin
        if (!rst_n) assert_reset_quiet_R10: assert (!start_o);
    end
endmodule

bind trig_qualifier tq_checker u_tq_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm_i    (arm_i),
    .disarm_i (disarm_i),
    .start_o  (start_o),
    .busy_o   (busy_o)
);

// File: tb/trig_qualifier_test.sv
module trig_qualifier_test;
    logic       clk = 0;
    logic       rst_n = 0;
    logic [7:0] pin_i = 0;
    logic [7:0] sel_mask_i = 0;
    logic       active_high_i = 1;
    logic [7:0] need_count_i = 0;
    logic [7:0] delay_ms_i = 0;
    logic       arm_i = 0;
    logic       disarm_i = 0;
    logic       ms_tick_i = 0;
    logic       start_o, busy_o;

    int total = 0;
    int fails = 0;
    bit done = 0;

    trig_qualifier uut (.*);

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic expect_sig(input logic act, input logic exp, input string tag);
        chk(act === exp, tag, int'(act), int'(exp));
    endtask

    function automatic logic [7:0] idle_pins(input logic pol, input logic [7:0] m, input logic [7:0] cur);
        return pol ? (cur & ~m) : (cur | m);
    endfunction

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    // drive pins now; start must appear only at the third negedge if exp=1
    task automatic ev(input logic [7:0] v, input logic exp, input string tag);
        pin_i = v;
        @(negedge clk); expect_sig(start_o, 1'b0, tag);
        @(negedge clk); expect_sig(start_o, 1'b0, tag);
        @(negedge clk); expect_sig(start_o, exp, tag);
        if (!exp) expect_sig(busy_o, 1'b1, tag);
    endtask

    task automatic arm(input logic [7:0] m, input logic pol, input logic [7:0] c, input logic [7:0] d);
        sel_mask_i = m; active_high_i = pol; need_count_i = c; delay_ms_i = d;
        arm_i = 1;
        @(negedge clk);
        arm_i = 0;
    endtask

    task automatic tick(input logic exp, input string tag);
        ms_tick_i = 1;
        @(negedge clk);
        ms_tick_i = 0;
        expect_sig(start_o, exp, tag);
        @(negedge clk);
    endtask

    task automatic wait_idle();
        repeat (3) @(negedge clk);
        disarm_i = 1; @(negedge clk); disarm_i = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; total++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20150426));
        repeat (3) @(negedge clk);
        expect_sig(start_o, 1'b0, "R10 start in reset");
        expect_sig(busy_o, 1'b0, "R10 busy in reset");
        rst_n = 1;
        @(negedge clk);
        expect_sig(busy_o, 1'b0, "R10 busy after reset");

        // R1 latency, count 0 delay 0
        pin_i = 0; settle();
        arm(8'h01, 1, 0, 0);
        expect_sig(busy_o, 1'b1, "R7 busy after arm");
        ev(8'h01, 1, "R1 latency");
        @(negedge clk);
        expect_sig(start_o, 1'b0, "R7 single pulse");
        expect_sig(busy_o, 1'b0, "R7 busy drops");

        // R5 level at arm fires immediately
        pin_i = 8'h01; settle();
        arm(8'h01, 1, 0, 0);
        expect_sig(start_o, 1'b1, "R5 arm-level fire");
        @(negedge clk);
        // R5 held pin does not count twice
        arm(8'h01, 1, 1, 0);
        repeat (4) @(negedge clk);
        expect_sig(start_o, 1'b0, "R5 held pin no recount");
        ev(8'h00, 0, "R3 return to inactive");
        ev(8'h01, 1, "R5 second rise fires");
        @(negedge clk);

        // R3 low polarity
        pin_i = 8'hFF; settle();
        arm(8'h80, 0, 0, 0);
        ev(8'h7F, 1, "R3 low polarity");
        @(negedge clk);

        // R4 simultaneous transitions count once; R2 deselected pin
        pin_i = 8'h00; settle();
        arm(8'h7F, 1, 1, 0);
        ev(8'h80, 0, "R2 deselected pin");
        ev(8'h8F, 0, "R4 simultaneous is one event");
        ev(8'h9F, 1, "R4 second event fires");
        @(negedge clk);

        // R9 disarm mid-count clears progress; disarm beats arm
        pin_i = 8'h00; settle();
        arm(8'hFF, 1, 2, 0);
        ev(8'h01, 0, "R9 before disarm");
        disarm_i = 1; @(negedge clk); disarm_i = 0;
        expect_sig(busy_o, 1'b0, "R9 idle after disarm");
        pin_i = 8'h00; settle();
        disarm_i = 1; arm_i = 1; @(negedge clk); disarm_i = 0; arm_i = 0;
        @(negedge clk);
        expect_sig(busy_o, 1'b0, "R9 disarm beats arm");
        arm(8'hFF, 1, 2, 0);
        ev(8'h01, 0, "R9 count restarted");
        ev(8'h03, 0, "R9 count restarted");
        ev(8'h07, 1, "R9 fires on third");
        @(negedge clk);

        // R8 arm while busy ignored, settings changed after arm
        pin_i = 8'h00; settle();
        arm(8'h0F, 1, 2, 0);
        need_count_i = 0; sel_mask_i = 8'hF0; active_high_i = 0;
        ev(8'h01, 0, "R8 first");
        arm_i = 1; @(negedge clk); arm_i = 0;
        ev(8'h03, 0, "R8 rearm ignored");
        ev(8'h07, 1, "R8 third fires");
        @(negedge clk);

        // R6 early ticks ignored
        pin_i = 8'h00; settle();
        arm(8'h01, 1, 1, 2);
        tick(0, "R6 early tick"); tick(0, "R6 early tick"); tick(0, "R6 early tick");
        ev(8'h01, 0, "R6 first event");
        ev(8'h00, 0, "R6 fall");
        ev(8'h01, 0, "R6 final enters delay");
        tick(0, "R6 tick 1 of 2");
        tick(1, "R6 tick 2 fires");
        expect_sig(busy_o, 1'b0, "R7 idle after delayed start");

        // random trials
        for (int t = 0; t < 60; t++) begin
            logic       pol;
            logic [7:0] m, c, d;
            pol = 1'($urandom % 2);
            m   = 8'($urandom % 255 + 1);
            c   = 8'($urandom % 5);
            d   = 8'($urandom % 4);
            pin_i = idle_pins(pol, m, 8'($urandom)); settle();
            arm(m, pol, c, d);
            need_count_i = 8'($urandom); delay_ms_i = 8'($urandom);
            for (int e = 0; e <= int'(c); e++) begin
                int idx;
                logic [7:0] nv;
                logic fin;
                idx = 0;
                do idx = int'($urandom % 8); while (!m[idx]);
                fin = (e == int'(c));
                nv = (pin_i & m) | (8'($urandom) & ~m);
                nv[idx] = pol;
                ev(nv, fin && (d == 0), "R4 random event");
                if (!fin) begin
                    nv = (pin_i & m) | (8'($urandom) & ~m);
                    nv[idx] = ~pol;
                    ev(nv, 0, "R2 random release");
                end
            end
            for (int k = 1; k <= int'(d); k++) tick(k == int'(d), "R6 random delay");
            if (d == 0) @(negedge clk);
            expect_sig(busy_o, 1'b0, "R7 random idle");
            wait_idle();
        end

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule